// File: doc/BRIEF.md
# Power Stage Protection Controller

This block sits between a byte-wide register bus and a set of power output stages: three high-side switches, four half-bridges (each with a high-side and a low-side FET) and one regulated supply output. Software turns the stages on as a group through a master enable bit. The block then keeps each stage off whenever a protection condition applies: a latched over-current on that stage, an over-temperature event, or a supply-voltage fault. Separate control bits let software turn off automatic thermal shutdown for high sides and for low sides. A third bit turns off automatic voltage-fault shutdown.

Over-current events are latched into sticky flags in a status register. Software clears a flag by writing 1 to its bit, and clearing the flag also re-enables the output the fault had turned off. The control register also accepts two write-only commands that request Stop or Sleep mode. A command is honoured only when the rest of the written byte carries no other control settings. An accepted command leaves the block as a one-cycle request pulse, and a pending interrupt request cancels it.

Top module: `pstage_guard`

## Requirements
- R1: After reset, the control register and all over-current flags are 0. Every stage enable, `stopReq` and `sleepReq` are low.
- R2: The control register is at address 0. Bit 7 is the master enable. Bit 4 turns off low-side thermal shutdown, bit 3 turns off high-side thermal shutdown, bit 2 turns off voltage-fault shutdown, and bits 1..0 select the slew rate. All of these bits are read/write. Bits 6..5 always read as 0.
- R3: The status register is at address 4. Bit 7 is the supply-output over-current flag and bits 2..0 are the flags for high sides 3..1. Bits 6..3 read as 0. A flag sets in the clock after its over-current input is sampled high.
- R4: Writing 1 to a status flag bit clears that flag, and writing 0 leaves it unchanged. If the over-current input is still high in the clock of the write, the flag stays set.
- R5: While a high-side or supply flag is set, that output's enable is low. Clearing the flag lets the enable return when no other condition holds it off.
- R6: When control bit 7 is 0, every stage enable is low.
- R7: With control bit 3 at 0, a high `htiIn` forces off all high-side switches and all half-bridge high-side FETs, in the same cycle.
- R8: With control bit 4 at 0, a high `htiIn` forces off all half-bridge low-side FETs, in the same cycle.
- R9: With control bit 2 at 0, a high `lviIn` or `hviIn` forces every stage enable low, in the same cycle.
- R10: A control write with bit 6 set (Stop) or bit 5 set (Sleep), and with bits 7, 4, 3 and 2 all 0, gives a one-cycle pulse on `stopReq` or `sleepReq` in the cycle after the write. If any of those four bits is 1, no pulse is produced. If both command bits are 1, only `stopReq` pulses.
- R11: A high `irqIn` in the clock of the command write cancels the request pulse.
- R12: Writes to any address other than 0 and 4 change nothing, and reads there return 0. `busRdata` is 0 when `busRd` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | 3 | Register address |
| busWr | input | 1 | Write strobe |
| busRd | input | 1 | Read strobe |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Read data (combinational) |
| hsOcIn | input | 3 | High-side over-current inputs |
| supOcIn | input | 1 | Supply-output over-current input |
| htiIn | input | 1 | High-temperature interrupt |
| lviIn | input | 1 | Low-voltage interrupt |
| hviIn | input | 1 | High-voltage interrupt |
| irqIn | input | 1 | Processor interrupt request |
| hsEn | output | 3 | High-side switch enables |
| hbHighEn | output | 4 | Half-bridge high-side FET enables |
| hbLowEn | output | 4 | Half-bridge low-side FET enables |
| supEn | output | 1 | Supply output enable |
| stopReq | output | 1 | Stop mode request pulse |
| sleepReq | output | 1 | Sleep mode request pulse |

## Verification
The enable logic is tried with each fault source alone and then under every combination of its disable bit. This separates high-side from low-side thermal coverage, and the voltage kill from the over-current kill. Flag tests cover three cases: a write of 0, a write of 1 while the fault persists, and a write of 1 after the fault has gone. Together they show which of set and clear wins, and that re-enable depends on the flag. Command writes are sent with each forbidden bit set alone, with only the slew bits set, with both commands at once, and with an interrupt present. These patterns show whether the guard mask, the priority and the cancellation are each correct.

// File: rtl/pstg_pkg.sv
package pstg_pkg;
  localparam int DATA_W = 8;
  localparam int PSON_BIT  = 7;
  localparam int STOP_BIT  = 6;
  localparam int SLEEP_BIT = 5;
  localparam int LTD_BIT   = 4;
  localparam int HTD_BIT   = 3;
  localparam int VFD_BIT   = 2;
  localparam int SUP_FLAG_BIT = 7;
  // bits kept in the control register
  localparam logic [DATA_W-1:0] CTRL_KEEP_MASK = 8'h9F;
  // bits that must be clear for a mode command to run
  localparam logic [DATA_W-1:0] CMD_GUARD_MASK = 8'h9C;

  typedef struct packed {
    logic ctrlWr;
    logic statWr;
    logic ctrlRd;
    logic statRd;
    logic stopCmd;
    logic sleepCmd;
  } busStrobe_t;
endpackage

// File: rtl/pstg_busctl.sv
module pstg_busctl
  import pstg_pkg::*;
#(
  parameter int ADDR_W    = 3,
  parameter int CTRL_ADDR = 0,
  parameter int STAT_ADDR = 4
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWr,
  input  logic              busRd,
  input  logic [DATA_W-1:0] busWdata,
  input  logic              irqIn,
  output busStrobe_t        strb
);
  localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_ADDR);
  localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(STAT_ADDR);

  logic hitCtrl, hitStat, guardClear, cmdOk;

  always_comb begin
    hitCtrl    = (busAddr == CTRL_A);
    hitStat    = (busAddr == STAT_A);
    guardClear = ((busWdata & CMD_GUARD_MASK) == '0);
    cmdOk      = busWr && hitCtrl && guardClear && !irqIn;

    strb.ctrlWr   = busWr && hitCtrl;
    strb.statWr   = busWr && hitStat;
    strb.ctrlRd   = busRd && hitCtrl;
    strb.statRd   = busRd && hitStat;
    strb.stopCmd  = cmdOk && busWdata[STOP_BIT];
    strb.sleepCmd = cmdOk && busWdata[SLEEP_BIT] && !busWdata[STOP_BIT];
  end
endmodule

// File: rtl/pstg_core.sv
module pstg_core
  import pstg_pkg::*;
#(
  parameter int NUM_HS = 3,
  parameter int NUM_HB = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  busStrobe_t        strb,
  input  logic [DATA_W-1:0] busWdata,
  input  logic [NUM_HS-1:0] hsOcIn,
  input  logic              supOcIn,
  input  logic              htiIn,
  input  logic              lviIn,
  input  logic              hviIn,
  output logic [DATA_W-1:0] busRdata,
  output logic [NUM_HS-1:0] hsEn,
  output logic [NUM_HB-1:0] hbHighEn,
  output logic [NUM_HB-1:0] hbLowEn,
  output logic              supEn,
  output logic              stopReq,
  output logic              sleepReq,
  output logic [DATA_W-1:0] ctrlQ,
  output logic [NUM_HS-1:0] hsFlagQ,
  output logic              supFlagQ
);
  logic [DATA_W-1:0] statView;
  logic powerOn, voltKill, hotHighKill, hotLowKill;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlQ    <= '0;
      supFlagQ <= 1'b0;
      stopReq  <= 1'b0;
      sleepReq <= 1'b0;
    end else begin
      if (strb.ctrlWr) ctrlQ <= busWdata & CTRL_KEEP_MASK;
      supFlagQ <= supOcIn | (supFlagQ & ~(strb.statWr & busWdata[SUP_FLAG_BIT]));
      stopReq  <= strb.stopCmd;
      sleepReq <= strb.sleepCmd;
    end
  end

  for (genvar i = 0; i < NUM_HS; i++) begin : g_hsFlag
    always_ff @(posedge clk) begin
      if (!rstN) hsFlagQ[i] <= 1'b0;
      else       hsFlagQ[i] <= hsOcIn[i] | (hsFlagQ[i] & ~(strb.statWr & busWdata[i]));
    end
  end

  always_comb begin
    statView = '0;
    statView[NUM_HS-1:0]   = hsFlagQ;
    statView[SUP_FLAG_BIT] = supFlagQ;
    if (strb.ctrlRd)      busRdata = ctrlQ;
    else if (strb.statRd) busRdata = statView;
    else                  busRdata = '0;
  end

  always_comb begin
    powerOn     = ctrlQ[PSON_BIT];
    voltKill    = (lviIn | hviIn) & ~ctrlQ[VFD_BIT];
    hotHighKill = htiIn & ~ctrlQ[HTD_BIT];
    hotLowKill  = htiIn & ~ctrlQ[LTD_BIT];
    supEn       = powerOn & ~voltKill & ~supFlagQ;
  end

  for (genvar i = 0; i < NUM_HS; i++) begin : g_hsEn
    assign hsEn[i] = powerOn & ~voltKill & ~hotHighKill & ~hsFlagQ[i];
  end

  for (genvar j = 0; j < NUM_HB; j++) begin : g_hbEn
    assign hbHighEn[j] = powerOn & ~voltKill & ~hotHighKill;
    assign hbLowEn[j]  = powerOn & ~voltKill & ~hotLowKill;
  end
endmodule

// File: rtl/pstage_guard.sv
module pstage_guard
  import pstg_pkg::*;
#(
  parameter int NUM_HS    = 3,
  parameter int NUM_HB    = 4,
  parameter int ADDR_W    = 3,
  parameter int CTRL_ADDR = 0,
  parameter int STAT_ADDR = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWr,
  input  logic              busRd,
  input  logic [7:0]        busWdata,
  output logic [7:0]        busRdata,
  input  logic [NUM_HS-1:0] hsOcIn,
  input  logic              supOcIn,
  input  logic              htiIn,
  input  logic              lviIn,
  input  logic              hviIn,
  input  logic              irqIn,
  output logic [NUM_HS-1:0] hsEn,
  output logic [NUM_HB-1:0] hbHighEn,
  output logic [NUM_HB-1:0] hbLowEn,
  output logic              supEn,
  output logic              stopReq,
  output logic              sleepReq
);
  busStrobe_t        strb;
  logic [DATA_W-1:0] ctrlQ;
  logic [NUM_HS-1:0] hsFlagQ;
  logic              supFlagQ;

  pstg_busctl #(
    .ADDR_W(ADDR_W), .CTRL_ADDR(CTRL_ADDR), .STAT_ADDR(STAT_ADDR)
  ) u_busctl (
    .busAddr(busAddr), .busWr(busWr), .busRd(busRd),
    .busWdata(busWdata), .irqIn(irqIn), .strb(strb)
  );

  pstg_core #(.NUM_HS(NUM_HS), .NUM_HB(NUM_HB)) u_core (
    .clk(clk), .rstN(rstN), .strb(strb), .busWdata(busWdata),
    .hsOcIn(hsOcIn), .supOcIn(supOcIn), .htiIn(htiIn),
    .lviIn(lviIn), .hviIn(hviIn), .busRdata(busRdata),
    .hsEn(hsEn), .hbHighEn(hbHighEn), .hbLowEn(hbLowEn), .supEn(supEn),
    .stopReq(stopReq), .sleepReq(sleepReq),
    .ctrlQ(ctrlQ), .hsFlagQ(hsFlagQ), .supFlagQ(supFlagQ)
  );
endmodule

// File: rtl/pstage_guard_chk.sv
module pstage_guard_chk #(
  parameter int NUM_HS = 3,
  parameter int NUM_HB = 4,
  parameter int ADDR_W = 3
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] busAddr,
  input logic              busWr,
  input logic [7:0]        busWdata,
  input logic [NUM_HS-1:0] hsOcIn,
  input logic              lviIn,
  input logic              hviIn,
  input logic              irqIn,
  input logic [NUM_HS-1:0] hsEn,
  input logic [NUM_HB-1:0] hbHighEn,
  input logic [NUM_HB-1:0] hbLowEn,
  input logic              supEn,
  input logic              stopReq,
  input logic              sleepReq,
  input logic [7:0]        ctrlQ,
  input logic [NUM_HS-1:0] hsFlagQ,
  input logic              supFlagQ
);
  AST_REQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    stopReq |=> !stopReq); // R10
  AST_REQ_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    !(stopReq && sleepReq)); // R10
  AST_STOP_GUARDED: assert property (@(posedge clk) disable iff (!rstN)
    stopReq |-> $past(busWr && busAddr == '0 && busWdata[6] && !irqIn
                      && busWdata[7] == 1'b0 && busWdata[4:2] == 3'b000)); // R10
  AST_UNPOWERED_OFF: assert property (@(posedge clk) disable iff (!rstN)
    !ctrlQ[7] |-> (hsEn == '0 && hbHighEn == '0 && hbLowEn == '0 && !supEn)); // R6
  AST_VOLT_OFF: assert property (@(posedge clk) disable iff (!rstN)
    ((lviIn || hviIn) && !ctrlQ[2]) |->
      (hsEn == '0 && hbHighEn == '0 && hbLowEn == '0 && !supEn)); // R9
  AST_FLAG_SETS: assert property (@(posedge clk) disable iff (!rstN)
    (hsOcIn != '0) |=> ((hsFlagQ & $past(hsOcIn)) == $past(hsOcIn))); // R3
  AST_FLAG_BLOCKS: assert property (@(posedge clk) disable iff (!rstN)
    ((hsFlagQ & hsEn) == '0) && !(supFlagQ && supEn)); // R5
endmodule

bind pstage_guard pstage_guard_chk #(.NUM_HS(NUM_HS), .NUM_HB(NUM_HB), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWr(busWr), .busWdata(busWdata),
  .hsOcIn(hsOcIn), .lviIn(lviIn), .hviIn(hviIn), .irqIn(irqIn),
  .hsEn(hsEn), .hbHighEn(hbHighEn), .hbLowEn(hbLowEn), .supEn(supEn),
  .stopReq(stopReq), .sleepReq(sleepReq),
  .ctrlQ(ctrlQ), .hsFlagQ(hsFlagQ), .supFlagQ(supFlagQ)
);

// File: tb/pstage_guard_test.sv
`timescale 1ns/1ps
module pstage_guard_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [2:0] busAddr = '0;
  logic busWr = 1'b0, busRd = 1'b0;
  logic [7:0] busWdata = '0;
  logic [7:0] busRdata;
  logic [2:0] hsOcIn = '0;
  logic supOcIn = 1'b0, htiIn = 1'b0, lviIn = 1'b0, hviIn = 1'b0, irqIn = 1'b0;
  logic [2:0] hsEn;
  logic [3:0] hbHighEn, hbLowEn;
  logic supEn, stopReq, sleepReq;

  int nChecks = 0;
  int nFails = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  pstage_guard uut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWr(busWr), .busRd(busRd),
    .busWdata(busWdata), .busRdata(busRdata), .hsOcIn(hsOcIn), .supOcIn(supOcIn),
    .htiIn(htiIn), .lviIn(lviIn), .hviIn(hviIn), .irqIn(irqIn),
    .hsEn(hsEn), .hbHighEn(hbHighEn), .hbLowEn(hbLowEn), .supEn(supEn),
    .stopReq(stopReq), .sleepReq(sleepReq)
  );

  // behavioural reference state
  int mCtrl = 0;
  int mFlags = 0;   // bit7 supply, bits2..0 high sides
  bit mStop = 0, mSleep = 0;

  always @(posedge clk) begin
    int clr;
    bit cmd;
    if (!rstN) begin
      mCtrl = 0; mFlags = 0; mStop = 0; mSleep = 0;
    end else begin
      clr = (busWr && busAddr == 4) ? (busWdata & 8'h87) : 0;
      mFlags = ((mFlags & ~clr) | hsOcIn | (supOcIn ? 8'h80 : 0)) & 8'h87;
      cmd = busWr && busAddr == 0 && !irqIn && busWdata[7] == 0 && busWdata[4] == 0
            && busWdata[3] == 0 && busWdata[2] == 0;
      mStop  = cmd && busWdata[6];
      mSleep = cmd && busWdata[5] && !busWdata[6];
      if (busWr && busAddr == 0) mCtrl = busWdata & 8'h9F;
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  // every-cycle comparison against the model
  always @(negedge clk) begin
    bit on, vk, th, tl;
    int expHs, expRd;
    if (rstN && !finished) begin
      on = mCtrl[7];
      vk = (lviIn || hviIn) && !mCtrl[2];
      th = htiIn && !mCtrl[3];
      tl = htiIn && !mCtrl[4];
      expHs = (on && !vk && !th) ? (~mFlags & 7) : 0;
      check("R5/R7 hsEn", hsEn, expHs);
      check("R7 hbHighEn", hbHighEn, (on && !vk && !th) ? 15 : 0);
      check("R8 hbLowEn", hbLowEn, (on && !vk && !tl) ? 15 : 0);
      check("R9 supEn", supEn, (on && !vk && !mFlags[7]) ? 1 : 0);
      check("R10 stopReq", stopReq, mStop);
      check("R10 sleepReq", sleepReq, mSleep);
      expRd = !busRd ? 0 : (busAddr == 0) ? mCtrl : (busAddr == 4) ? mFlags : 0;
      check("R12 busRdata", busRdata, expRd);
    end
  end

  task automatic wr(input int a, input int d);
    @(posedge clk); #2;
    busWr = 1; busAddr = 3'(a); busWdata = 8'(d);
    @(posedge clk); #2;
    busWr = 0; busWdata = 0; busAddr = 0;
  endtask

  task automatic rd(input int a, output int d);
    @(posedge clk); #2;
    busRd = 1; busAddr = 3'(a);
    #3 d = busRdata;
    @(posedge clk); #2;
    busRd = 0; busAddr = 0;
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    int v;
    tick(3);
    rstN = 1;
    tick(1);
    // R1 reset state
    check("R1 enables", {hsEn, hbHighEn, hbLowEn, supEn}, 0);
    check("R1 requests", {stopReq, sleepReq}, 0);
    rd(0, v); check("R1 ctrl", v, 0);
    rd(4, v); check("R1 status", v, 0);

    // R2 read/write, bits 6..5 read 0
    wr(0, 8'hFF); rd(0, v); check("R2 ctrl all ones", v, 8'h9F);
    wr(0, 8'h83); rd(0, v); check("R2 ctrl slew", v, 8'h83);
    wr(0, 8'h80);
    check("R6 powered all on", {hsEn, hbHighEn, hbLowEn, supEn}, 12'hFFF);

    // R3/R4/R5 over-current flags
    hsOcIn = 3'b001; tick(1); hsOcIn = 0; tick(1);
    check("R5 hs1 off", hsEn, 3'b110);
    rd(4, v); check("R3 hs1 flag", v, 8'h01);
    wr(4, 8'h00); rd(4, v); check("R4 write0 no effect", v, 8'h01);
    hsOcIn = 3'b001; wr(4, 8'h01); hsOcIn = 0;
    rd(4, v); check("R4 set wins", v, 8'h01);
    wr(4, 8'h01); rd(4, v); check("R4 cleared", v, 8'h00);
    check("R5 hs1 back on", hsEn, 3'b111);
    supOcIn = 1; hsOcIn = 3'b100; tick(1); supOcIn = 0; hsOcIn = 0; tick(1);
    check("R5 supply off", supEn, 0);
    rd(4, v); check("R3 layout", v, 8'h84);
    wr(4, 8'h80); check("R5 supply back", supEn, 1);
    wr(4, 8'h04);

    // R7/R8 thermal
    htiIn = 1; tick(1);
    check("R7 hs off", {hsEn, hbHighEn}, 0);
    check("R8 low off", hbLowEn, 0);
    wr(0, 8'h88); tick(1);
    check("R7 high kept", {hsEn, hbHighEn}, 7'h7F);
    check("R8 low still off", hbLowEn, 0);
    wr(0, 8'h90); tick(1);
    check("R8 low kept", hbLowEn, 4'hF);
    check("R7 high off again", hbHighEn, 0);
    htiIn = 0; wr(0, 8'h80);

    // R9 voltage
    lviIn = 1; tick(1);
    check("R9 lvi all off", {hsEn, hbHighEn, hbLowEn, supEn}, 0);
    lviIn = 0; hviIn = 1; tick(1);
    check("R9 hvi all off", {hsEn, hbHighEn, hbLowEn, supEn}, 0);
    wr(0, 8'h84); tick(1);
    check("R9 disabled kept", {hsEn, hbHighEn, hbLowEn, supEn}, 12'hFFF);
    hviIn = 0;

    // R6 master off
    wr(0, 8'h18); tick(1);
    check("R6 all off", {hsEn, hbHighEn, hbLowEn, supEn}, 0);

    // R10 commands
    wr(0, 8'h40); check("R10 stop pulse", {stopReq, sleepReq}, 2'b10);
    tick(1); check("R10 stop one cycle", stopReq, 0);
    wr(0, 8'h43); check("R10 stop with slew", stopReq, 1);
    wr(0, 8'hC0); check("R10 bit7 blocks", {stopReq, sleepReq}, 0);
    wr(0, 8'h44); check("R10 bit2 blocks", {stopReq, sleepReq}, 0);
    wr(0, 8'h30); check("R10 bit4 blocks", {stopReq, sleepReq}, 0);
    wr(0, 8'h60); check("R10 stop priority", {stopReq, sleepReq}, 2'b10);
    wr(0, 8'h20); check("R10 sleep pulse", {stopReq, sleepReq}, 2'b01);
    irqIn = 1; wr(0, 8'h40); irqIn = 0;
    check("R11 irq cancels", {stopReq, sleepReq}, 0);

    // R12 other addresses
    wr(0, 8'h81); hsOcIn = 3'b010; tick(1); hsOcIn = 0;
    wr(2, 8'hFF); wr(6, 8'hFF);
    rd(0, v); check("R12 ctrl untouched", v, 8'h81);
    rd(4, v); check("R12 status untouched", v, 8'h02);
    rd(2, v); check("R12 read zero", v, 0);
    rd(5, v); check("R12 read zero 5", v, 0);

    tick(2);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule